// File: doc/BRIEF.md
# Per-Counter User-Mode Access Filter

This block decides how an unprivileged access to one performance counter is handled. The access can go to the counter value itself, or to that counter's bit in the count-enable set/clear or overflow set/clear controls. The selector names an event counter by index, the cycle counter, or the fixed instruction counter. The block combines the selector with a 64-bit user-access mask register and the global user controls. These controls are a mask-mode enable, a general user enable, and one read-only control for each counter class.

The result is one of four classes: read-as-zero/write-ignored, read-only, read/write, or a request to trap. The block also raises a flag for a write that arrives while access is read-only, and a strobe that lets a write to the counter-zeroing register take effect. The decision is purely combinational. The counters and the trap machinery sit outside the block.

Top module: `pmu_user_filter`

## Requirements
- R1: With `maskModeEn`=1 and the selected counter's mask bit at 0, the access is classed `razWi`. `wrTrap` and `zeroApply` stay low.
- R2: With `maskModeEn`=1 and the selected mask bit at 1, the access is `roAcc` when the class read-only control is 1 and `rwAcc` when it is 0. The class read-only controls are `evtRoEn` for event counters, `cycRoEn` for the cycle counter and `insRoEn` for the instruction counter.
- R3: Mask bit m (0..30) belongs to event counter m, bit 31 to the cycle counter and bit 32 to the instruction counter. The `selClass` encoding is 0 = event, 1 = cycle, 2 = instruction, 3 = none.
- R4: Mask bits 63..33 have no effect on any output.
- R5: The access is classed `razWi` in any mode when any of these holds: the selector names no counter (`selClass`=3); an event index is at or above `NUM_EVT`; or the instruction counter is selected while `HAS_INSTR`=0. In the last case mask bit 32 behaves as a reserved zero.
- R6: With `maskModeEn`=0 the mask is ignored. When `userEn`=0 the access raises `accTrap`. When `userEn`=1 the access is `roAcc` or `rwAcc` according to the class read-only control.
- R7: `wrTrap` is high exactly when a write (`isWrite`=1) meets a `roAcc` result.
- R8: `zeroApply` is high only for a write to the zeroing register (`target`=3) whose result is `rwAcc`. A zeroing write classed `razWi` is ignored.
- R9: Exactly one of `razWi`, `roAcc`, `rwAcc`, `accTrap` is high for every input.
- R10: The classification is the same whether `target` names the counter value (0), its enable set/clear bit (1) or its overflow set/clear bit (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| selClass | input | 2 | Counter class: 0 event, 1 cycle, 2 instruction, 3 none |
| selIdx | input | IDX_W | Event counter index |
| isWrite | input | 1 | Access is a write |
| target | input | 2 | 0 counter value, 1 enable set/clear, 2 overflow set/clear, 3 zeroing register |
| userMaskReg | input | 64 | Per-counter user-access mask register |
| maskModeEn | input | 1 | Per-counter mask mode active |
| userEn | input | 1 | General user access enable |
| evtRoEn | input | 1 | Event counters read-only |
| cycRoEn | input | 1 | Cycle counter read-only |
| insRoEn | input | 1 | Instruction counter read-only |
| razWi | output | 1 | Read as zero, writes ignored |
| roAcc | output | 1 | Read-only access |
| rwAcc | output | 1 | Read/write access |
| accTrap | output | 1 | Access not permitted, trap requested |
| wrTrap | output | 1 | Write attempted on a read-only access |
| zeroApply | output | 1 | Counter-zeroing write takes effect |

## Verification
The block holds no state, so every output is due in the same cycle that its inputs settle. No result waits for a later cycle. The bench drives a new input vector just after each rising clock edge and compares every output at the following falling edge. Each comparison therefore sees only the vector applied half a cycle earlier. Two instances run side by side, one with the instruction counter present and one without, and both are checked against one behavioural model on every clock.

// File: rtl/pmu_ufilt_pkg.sv
package pmu_ufilt_pkg;

  localparam int REG_W   = 64;
  localparam int MASK_W  = 33;
  localparam int EVT_MAX = 31;
  localparam int CYC_BIT = 31;
  localparam int INS_BIT = 32;

  typedef enum logic [1:0] {
    SEL_EVENT = 2'd0,
    SEL_CYCLE = 2'd1,
    SEL_INSTR = 2'd2,
    SEL_NONE  = 2'd3
  } selClass_e;

  typedef enum logic [1:0] {
    TGT_COUNT  = 2'd0,
    TGT_ENABLE = 2'd1,
    TGT_OVFL   = 2'd2,
    TGT_ZERO   = 2'd3
  } target_e;

  // strobes from the lookup datapath to the decision control
  typedef struct packed {
    logic selValid;
    logic maskBit;
    logic classRo;
    logic isWr;
    logic zeroTgt;
  } lookup_t;

  typedef struct packed {
    logic razWi;
    logic ro;
    logic rw;
    logic accTrap;
    logic wrTrap;
    logic zeroApply;
  } verdict_t;

endpackage

// File: rtl/pmu_ufilt_mask.sv
module pmu_ufilt_mask
  import pmu_ufilt_pkg::*;
#(
  parameter int NUM_EVT   = 20,
  parameter bit HAS_INSTR = 1'b1
) (
  input  logic [REG_W-1:0]  userMaskReg,
  output logic [MASK_W-1:0] effMask
);

  // upper reserved bits and unbacked bits are simply not forwarded
  logic unusedBits;
  assign unusedBits = ^userMaskReg;

  for (genvar i = 0; i < EVT_MAX; i++) begin : g_evt
    if (i < NUM_EVT) begin : g_live
      assign effMask[i] = userMaskReg[i];
    end else begin : g_dead
      assign effMask[i] = 1'b0;
    end
  end

  assign effMask[CYC_BIT] = userMaskReg[CYC_BIT];

  if (HAS_INSTR) begin : g_ins
    assign effMask[INS_BIT] = userMaskReg[INS_BIT];
  end else begin : g_noins
    assign effMask[INS_BIT] = 1'b0;
  end

endmodule

// File: rtl/pmu_ufilt_dp.sv
module pmu_ufilt_dp
  import pmu_ufilt_pkg::*;
#(
  parameter int NUM_EVT   = 20,
  parameter bit HAS_INSTR = 1'b1,
  parameter int IDX_W     = 5
) (
  input  logic [1:0]        selClass,
  input  logic [IDX_W-1:0]  selIdx,
  input  logic              isWrite,
  input  logic [1:0]        target,
  input  logic [MASK_W-1:0] effMask,
  input  logic              evtRoEn,
  input  logic              cycRoEn,
  input  logic              insRoEn,
  output lookup_t           lk
);

  localparam logic [IDX_W:0] EVT_LIM = (IDX_W+1)'(NUM_EVT);

  selClass_e        cls;
  logic [MASK_W-1:0] selVec;
  logic             idxInRange;

  assign cls        = selClass_e'(selClass);
  assign idxInRange = ({1'b0, selIdx} < EVT_LIM);

  // one-hot pointer into the effective mask
  for (genvar i = 0; i < EVT_MAX; i++) begin : g_sel
    assign selVec[i] = (cls == SEL_EVENT) && (selIdx == IDX_W'(i));
  end
  assign selVec[CYC_BIT] = (cls == SEL_CYCLE);
  assign selVec[INS_BIT] = (cls == SEL_INSTR);

  always_comb begin
    lk.maskBit = |(selVec & effMask);
    lk.isWr    = isWrite;
    lk.zeroTgt = (target_e'(target) == TGT_ZERO);
    unique case (cls)
      SEL_EVENT: begin lk.selValid = idxInRange; lk.classRo = evtRoEn; end
      SEL_CYCLE: begin lk.selValid = 1'b1;       lk.classRo = cycRoEn; end
      SEL_INSTR: begin lk.selValid = HAS_INSTR;  lk.classRo = insRoEn; end
      default:   begin lk.selValid = 1'b0;       lk.classRo = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/pmu_ufilt_ctl.sv
module pmu_ufilt_ctl
  import pmu_ufilt_pkg::*;
(
  input  lookup_t  lk,
  input  logic     maskModeEn,
  input  logic     userEn,
  output verdict_t vd
);

  always_comb begin
    vd = '0;
    if (!lk.selValid) begin
      vd.razWi = 1'b1;
    end else if (maskModeEn) begin
      if (!lk.maskBit)     vd.razWi = 1'b1;
      else if (lk.classRo) vd.ro    = 1'b1;
      else                 vd.rw    = 1'b1;
    end else if (!userEn) begin
      vd.accTrap = 1'b1;
    end else if (lk.classRo) begin
      vd.ro = 1'b1;
    end else begin
      vd.rw = 1'b1;
    end
    vd.wrTrap    = vd.ro & lk.isWr;
    vd.zeroApply = vd.rw & lk.isWr & lk.zeroTgt;
  end

endmodule

// File: rtl/pmu_user_filter.sv
module pmu_user_filter
  import pmu_ufilt_pkg::*;
#(
  parameter int NUM_EVT   = 20,
  parameter bit HAS_INSTR = 1'b1,
  parameter int IDX_W     = 5
) (
  input  logic [1:0]       selClass,
  input  logic [IDX_W-1:0] selIdx,
  input  logic             isWrite,
  input  logic [1:0]       target,
  input  logic [63:0]      userMaskReg,
  input  logic             maskModeEn,
  input  logic             userEn,
  input  logic             evtRoEn,
  input  logic             cycRoEn,
  input  logic             insRoEn,
  output logic             razWi,
  output logic             roAcc,
  output logic             rwAcc,
  output logic             accTrap,
  output logic             wrTrap,
  output logic             zeroApply
);

  logic [MASK_W-1:0] effMask;
  lookup_t           lk;
  verdict_t          vd;

  pmu_ufilt_mask #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR)) u_mask (
    .userMaskReg (userMaskReg),
    .effMask     (effMask)
  );

  pmu_ufilt_dp #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR), .IDX_W(IDX_W)) u_dp (
    .selClass (selClass),
    .selIdx   (selIdx),
    .isWrite  (isWrite),
    .target   (target),
    .effMask  (effMask),
    .evtRoEn  (evtRoEn),
    .cycRoEn  (cycRoEn),
    .insRoEn  (insRoEn),
    .lk       (lk)
  );

  pmu_ufilt_ctl u_ctl (
    .lk         (lk),
    .maskModeEn (maskModeEn),
    .userEn     (userEn),
    .vd         (vd)
  );

  assign razWi     = vd.razWi;
  assign roAcc     = vd.ro;
  assign rwAcc     = vd.rw;
  assign accTrap   = vd.accTrap;
  assign wrTrap    = vd.wrTrap;
  assign zeroApply = vd.zeroApply;

endmodule

// File: rtl/pmu_user_filter_chk.sv
module pmu_user_filter_chk (
  input logic [1:0] selClass,
  input logic       isWrite,
  input logic [1:0] target,
  input logic       maskModeEn,
  input logic       razWi,
  input logic       roAcc,
  input logic       rwAcc,
  input logic       accTrap,
  input logic       wrTrap,
  input logic       zeroApply
);

  always_comb begin
    if (!$isunknown({selClass, isWrite, target, maskModeEn,
                     razWi, roAcc, rwAcc, accTrap, wrTrap, zeroApply})) begin
      p_one_class_r9: assert ($countones({razWi, roAcc, rwAcc, accTrap}) == 1)
        else $error("class outputs not one-hot");
      p_wrtrap_src_r7: assert (!wrTrap || (roAcc && isWrite))
        else $error("write trap without read-only write");
      p_zero_gate_r8: assert (!zeroApply || (rwAcc && isWrite && target == 2'd3))
        else $error("zeroing applied outside read/write");
      p_none_raz_r5: assert (selClass != 2'd3 || razWi)
        else $error("empty selector not read-as-zero");
      p_mask_no_trap_r1: assert (!maskModeEn || !accTrap)
        else $error("trap raised in mask mode");
      p_raz_quiet_r1: assert (!razWi || (!wrTrap && !zeroApply))
        else $error("read-as-zero access had a side effect");
    end
  end

endmodule

bind pmu_user_filter pmu_user_filter_chk u_chk (
  .selClass   (selClass),
  .isWrite    (isWrite),
  .target     (target),
  .maskModeEn (maskModeEn),
  .razWi      (razWi),
  .roAcc      (roAcc),
  .rwAcc      (rwAcc),
  .accTrap    (accTrap),
  .wrTrap     (wrTrap),
  .zeroApply  (zeroApply)
);

// File: tb/tb_pmu_user_filter.sv
module tb_pmu_user_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NEVT       = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  selClass;
  logic [4:0]  selIdx;
  logic        isWrite;
  logic [1:0]  target;
  logic [63:0] userMaskReg;
  logic        maskModeEn, userEn, evtRoEn, cycRoEn, insRoEn;
  logic        razWi, roAcc, rwAcc, accTrap, wrTrap, zeroApply;
  logic        razWiB, roAccB, rwAccB, accTrapB, wrTrapB, zeroApplyB;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pmu_user_filter dut (
    .selClass(selClass), .selIdx(selIdx), .isWrite(isWrite), .target(target),
    .userMaskReg(userMaskReg), .maskModeEn(maskModeEn), .userEn(userEn),
    .evtRoEn(evtRoEn), .cycRoEn(cycRoEn), .insRoEn(insRoEn),
    .razWi(razWi), .roAcc(roAcc), .rwAcc(rwAcc), .accTrap(accTrap),
    .wrTrap(wrTrap), .zeroApply(zeroApply)
  );

  pmu_user_filter #(.HAS_INSTR(1'b0)) dutNoIns (
    .selClass(selClass), .selIdx(selIdx), .isWrite(isWrite), .target(target),
    .userMaskReg(userMaskReg), .maskModeEn(maskModeEn), .userEn(userEn),
    .evtRoEn(evtRoEn), .cycRoEn(cycRoEn), .insRoEn(insRoEn),
    .razWi(razWiB), .roAcc(roAccB), .rwAcc(rwAccB), .accTrap(accTrapB),
    .wrTrap(wrTrapB), .zeroApply(zeroApplyB)
  );

  // behavioural model: returns {raz, ro, rw, trap, wrTrap, zeroApply}
  function automatic logic [5:0] model(bit hasIns);
    int  pos = 0;
    bit  exists = 0;
    bit  roSel = 0;
    int  mode;  // 0 raz, 1 ro, 2 rw, 3 trap
    case (selClass)
      2'd0: begin exists = (int'(selIdx) < NEVT); pos = int'(selIdx); roSel = evtRoEn; end
      2'd1: begin exists = 1; pos = 31; roSel = cycRoEn; end
      2'd2: begin exists = hasIns; pos = 32; roSel = insRoEn; end
      default: exists = 0;
    endcase
    if (!exists)          mode = 0;
    else if (maskModeEn)  mode = userMaskReg[pos] ? (roSel ? 1 : 2) : 0;
    else if (!userEn)     mode = 3;
    else                  mode = roSel ? 1 : 2;
    return {mode == 0, mode == 1, mode == 2, mode == 3,
            (mode == 1) && isWrite,
            (mode == 2) && isWrite && (target == 2'd3)};
  endfunction

  task automatic compare(string tag);
    logic [5:0] gotA, gotB, expA, expB;
    gotA = {razWi, roAcc, rwAcc, accTrap, wrTrap, zeroApply};
    gotB = {razWiB, roAccB, rwAccB, accTrapB, wrTrapB, zeroApplyB};
    expA = model(1'b1);
    expB = model(1'b0);
    checks += 2;
    if (gotA !== expA) begin
      errors++;
      $display("FAIL %s dut got %b expected %b", tag, gotA, expA);
    end
    if (gotB !== expB) begin
      errors++;
      $display("FAIL %s dutNoIns got %b expected %b", tag, gotB, expB);
    end
  endtask

  task automatic expectBit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [4:0] ix, input logic w,
                       input logic [1:0] t, input logic [63:0] m,
                       input logic mm, input logic ue,
                       input logic er, input logic cr, input logic ir);
    @(posedge clk);
    #1;
    selClass = c; selIdx = ix; isWrite = w; target = t; userMaskReg = m;
    maskModeEn = mm; userEn = ue; evtRoEn = er; cycRoEn = cr; insRoEn = ir;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    selClass = 0; selIdx = 0; isWrite = 0; target = 0; userMaskReg = '0;
    maskModeEn = 0; userEn = 0; evtRoEn = 0; cycRoEn = 0; insRoEn = 0;
    @(negedge clk);
    // initial state: all controls off gives a trap request (R6)
    compare("R6 initial");
    expectBit("R6 initial trap", accTrap, 1'b1);

    // R1: mask mode with cleared bits hides every counter
    drive(2'd0, 5'd5, 1'b0, 2'd0, 64'h0, 1, 1, 0, 0, 0);
    compare("R1 event read"); expectBit("R1 event raz", razWi, 1'b1);
    drive(2'd1, 5'd0, 1'b1, 2'd1, 64'h0, 1, 1, 1, 1, 1);
    compare("R1 cycle write"); expectBit("R1 no wrTrap", wrTrap, 1'b0);
    drive(2'd2, 5'd0, 1'b1, 2'd3, 64'h0, 1, 1, 0, 0, 0);
    compare("R1 instr zero"); expectBit("R1 zero ignored", zeroApply, 1'b0);

    // R3: bit position mapping
    drive(2'd0, 5'd5, 1'b0, 2'd0, 64'h20, 1, 0, 0, 0, 0);
    compare("R3 bit5"); expectBit("R3 bit5 rw", rwAcc, 1'b1);
    drive(2'd0, 5'd4, 1'b0, 2'd0, 64'h20, 1, 0, 0, 0, 0);
    compare("R3 bit4 clear"); expectBit("R3 bit4 raz", razWi, 1'b1);
    drive(2'd1, 5'd0, 1'b0, 2'd0, 64'h8000_0000, 1, 0, 0, 0, 0);
    compare("R3 cycle bit"); expectBit("R3 cycle rw", rwAcc, 1'b1);
    drive(2'd0, 5'd0, 1'b0, 2'd0, 64'h8000_0000, 1, 0, 0, 0, 0);
    compare("R3 event0 off"); expectBit("R3 event0 raz", razWi, 1'b1);
    drive(2'd2, 5'd0, 1'b0, 2'd0, 64'h1_0000_0000, 1, 0, 0, 0, 0);
    compare("R3 instr bit"); expectBit("R3 instr rw", rwAcc, 1'b1);

    // R2: class read-only controls
    drive(2'd0, 5'd3, 1'b0, 2'd0, 64'h1_FFFF_FFFF, 1, 0, 1, 0, 0);
    compare("R2 event ro"); expectBit("R2 event ro", roAcc, 1'b1);
    drive(2'd1, 5'd3, 1'b0, 2'd0, 64'h1_FFFF_FFFF, 1, 0, 1, 0, 0);
    compare("R2 cycle rw"); expectBit("R2 cycle rw", rwAcc, 1'b1);
    drive(2'd2, 5'd3, 1'b0, 2'd0, 64'h1_FFFF_FFFF, 1, 0, 0, 0, 1);
    compare("R2 instr ro"); expectBit("R2 instr ro", roAcc, 1'b1);

    // R4: reserved upper bits do nothing
    drive(2'd1, 5'd0, 1'b0, 2'd0, 64'hFFFF_FFFE_0000_0000, 1, 1, 0, 0, 0);
    compare("R4 upper bits"); expectBit("R4 cycle raz", razWi, 1'b1);

    // R5: nonexistent counters
    drive(2'd0, 5'd20, 1'b0, 2'd0, '1, 1, 1, 0, 0, 0);
    compare("R5 index limit"); expectBit("R5 idx20 raz", razWi, 1'b1);
    drive(2'd0, 5'd19, 1'b0, 2'd0, '1, 1, 1, 0, 0, 0);
    compare("R5 last index"); expectBit("R5 idx19 rw", rwAcc, 1'b1);
    drive(2'd3, 5'd0, 1'b1, 2'd0, '1, 0, 1, 0, 0, 0);
    compare("R5 no selector"); expectBit("R5 none raz", razWi, 1'b1);
    drive(2'd2, 5'd0, 1'b0, 2'd0, '1, 0, 0, 0, 0, 0);
    compare("R5 absent instr"); expectBit("R5 noins raz", razWiB, 1'b1);

    // R6: mask mode off
    drive(2'd0, 5'd2, 1'b0, 2'd0, 64'h0, 0, 1, 0, 0, 0);
    compare("R6 user on"); expectBit("R6 mask ignored rw", rwAcc, 1'b1);
    drive(2'd0, 5'd2, 1'b0, 2'd0, '1, 0, 0, 0, 0, 0);
    compare("R6 user off"); expectBit("R6 trap", accTrap, 1'b1);
    drive(2'd1, 5'd2, 1'b0, 2'd0, 64'h0, 0, 1, 0, 1, 0);
    compare("R6 cycle ro"); expectBit("R6 cycle ro", roAcc, 1'b1);

    // R7: write on read-only
    drive(2'd0, 5'd1, 1'b1, 2'd2, '1, 1, 0, 1, 0, 0);
    compare("R7 ro write"); expectBit("R7 wrTrap", wrTrap, 1'b1);
    drive(2'd0, 5'd1, 1'b1, 2'd2, '1, 1, 0, 0, 0, 0);
    compare("R7 rw write"); expectBit("R7 no wrTrap", wrTrap, 1'b0);

    // R8: zeroing write
    drive(2'd1, 5'd0, 1'b1, 2'd3, '1, 1, 0, 0, 0, 0);
    compare("R8 zero rw"); expectBit("R8 zero applied", zeroApply, 1'b1);
    drive(2'd1, 5'd0, 1'b0, 2'd3, '1, 1, 0, 0, 0, 0);
    compare("R8 zero read"); expectBit("R8 read no zero", zeroApply, 1'b0);
    drive(2'd1, 5'd0, 1'b1, 2'd3, 64'h0, 1, 0, 0, 0, 0);
    compare("R8 zero raz"); expectBit("R8 raz no zero", zeroApply, 1'b0);

    // R10: every control target classifies alike
    for (int t = 0; t < 3; t++) begin
      drive(2'd0, 5'd7, 1'b1, 2'(t), 64'h80, 1, 0, 1, 0, 0);
      compare("R10 target ro"); expectBit("R10 ro per target", roAcc, 1'b1);
      drive(2'd0, 5'd7, 1'b1, 2'(t), 64'h0, 1, 0, 1, 0, 0);
      compare("R10 target raz"); expectBit("R10 raz per target", razWi, 1'b1);
    end

    // R9: mixed stimulus against the model every clock
    for (int n = 0; n < 3000; n++) begin
      drive(2'($urandom), 5'($urandom), 1'($urandom), 2'($urandom),
            {$urandom, $urandom}, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      compare("R9 mixed");
    end

    finishRun();
  end

endmodule